// File: doc/BRIEF.md
# Level-Sensitive Masked Interrupt Controller

This block gathers up to 32 level-sensitive interrupt request lines into a single processor interrupt. Each request line is copied into a pending register on every clock edge, so a pending bit is high exactly while its line is high. Software controls which sources may reach the processor through a 32-bit enable mask. The one interrupt output is raised whenever any source is both pending and enabled.

Software reaches the block through a simple synchronous register port. The port has an address, a write strobe with write data, and a read strobe with read data. All accesses are full 32-bit words. The enable mask can be read and written. The pending register can only be read. Two further word addresses accept writes and keep no state. Every other address reads as zero and ignores writes.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: Pending bit i is set on the clock edge after request line i is seen high, and cleared on the clock edge after it is seen low. It is never held once its line drops, and software cannot clear it.
- R2: `irq_o` is high exactly when the bitwise AND of the mask register and the pending register, as they stood before the previous edge, is nonzero.
- R3: A write to byte offset 0x04 replaces all mask bits with the write data on that edge. A read from 0x04 returns the mask.
- R4: A read from byte offset 0x0C returns the pending register, zero-extended to 32 bits.
- R5: Writes to byte offsets 0x00 and 0x14 are accepted and change no state. Both the mask readback and `irq_o` are unchanged afterwards.
- R6: Reads from any offset other than 0x04 and 0x0C return zero. Writes to any offset other than 0x00, 0x04 and 0x14 change nothing.
- R7: While reset (active high, synchronous) is applied, the mask, pending, `irq_o` and `rd_data_o` are all zero.
- R8: Read data is registered. It shows the addressed value in the cycle after the edge that sampled `rd_en_i`, and it is zero after an edge where `rd_en_i` was low.
- R9: `irq_o` lags a pending-bit or mask change by one clock edge. Right after a mask write edge, `irq_o` still shows the old value, and it takes the new value at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | NUM_SRC | Level-sensitive interrupt request lines |
| addr_i | input | 8 | Byte address of the register access |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 32 | Registered read data |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
If the mask is corrupted, the error shows up in the very next register read of 0x04. It also changes `irq_o` one edge after any pending source that it wrongly enables or disables. If the pending register latches or lags its lines, a read of 0x0C returns a bit that no longer matches the line within two cycles of that line changing. The bench compares `irq_o` against a model at both the cycle before and the cycle after each change. An extra or missing register stage in the output path therefore shows up as a mismatch.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFS_LEVEL = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_MASK  = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_PEND  = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_CTRL  = 8'h14;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_LEVEL,
        SEL_MASK,
        SEL_PEND,
        SEL_CTRL
    } reg_sel_e;

    typedef struct packed {
        logic              wr;
        logic              rd;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } bus_req_t;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        case (a)
            OFS_LEVEL: return SEL_LEVEL;
            OFS_MASK:  return SEL_MASK;
            OFS_PEND:  return SEL_PEND;
            OFS_CTRL:  return SEL_CTRL;
            default:   return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/irq_in_stage.sv
module irq_in_stage #(
    parameter int NUM_SRC     = 32,
    parameter int SYNC_STAGES = 0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] req_i,
    output logic [NUM_SRC-1:0] pend_o
);
    logic [NUM_SRC-1:0] stage [SYNC_STAGES+1];

    assign stage[0] = req_i;

    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
        always_ff @(posedge clk) begin
            if (rst) stage[i+1] <= '0;
            else     stage[i+1] <= stage[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pend_o <= '0;
        else     pend_o <= stage[SYNC_STAGES];
    end
endmodule

// File: rtl/irq_regs.sv
module irq_regs
    import lvl_irq_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  bus_req_t           bus_i,
    input  logic [NUM_SRC-1:0] pend_i,
    output logic [NUM_SRC-1:0] mask_o,
    output logic [DATA_W-1:0]  rd_data_o
);
    reg_sel_e          sel;
    logic [DATA_W-1:0] rd_next;

    assign sel = decode_addr(bus_i.addr);

    always_ff @(posedge clk) begin
        if (rst)                             mask_o <= '0;
        else if (bus_i.wr && sel == SEL_MASK) mask_o <= bus_i.data[NUM_SRC-1:0];
    end

    always_comb begin
        rd_next = '0;
        if (bus_i.rd) begin
            case (sel)
                SEL_MASK: rd_next[NUM_SRC-1:0] = mask_o;
                SEL_PEND: rd_next[NUM_SRC-1:0] = pend_i;
                default:  rd_next = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rd_data_o <= '0;
        else     rd_data_o <= rd_next;
    end
endmodule

// File: rtl/irq_out.sv
module irq_out #(
    parameter int NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] pend_i,
    input  logic [NUM_SRC-1:0] mask_i,
    output logic               irq_o
);
    always_ff @(posedge clk) begin
        if (rst) irq_o <= 1'b0;
        else     irq_o <= |(pend_i & mask_i);
    end
endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl
    import lvl_irq_pkg::*;
#(
    parameter int NUM_SRC     = 32,
    parameter int SYNC_STAGES = 0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] req_i,
    input  logic [7:0]         addr_i,
    input  logic               wr_en_i,
    input  logic [31:0]        wr_data_i,
    input  logic               rd_en_i,
    output logic [31:0]        rd_data_o,
    output logic               irq_o
);
    bus_req_t           bus;
    logic [NUM_SRC-1:0] pend_q;
    logic [NUM_SRC-1:0] mask_q;

    assign bus = '{wr: wr_en_i, rd: rd_en_i, addr: addr_i, data: wr_data_i};

    irq_in_stage #(.NUM_SRC(NUM_SRC), .SYNC_STAGES(SYNC_STAGES)) u_in (
        .clk(clk), .rst(rst), .req_i(req_i), .pend_o(pend_q)
    );

    irq_regs #(.NUM_SRC(NUM_SRC)) u_regs (
        .clk(clk), .rst(rst), .bus_i(bus), .pend_i(pend_q),
        .mask_o(mask_q), .rd_data_o(rd_data_o)
    );

    irq_out #(.NUM_SRC(NUM_SRC)) u_out (
        .clk(clk), .rst(rst), .pend_i(pend_q), .mask_i(mask_q), .irq_o(irq_o)
    );
endmodule

// File: rtl/lvl_irq_ctrl_chk.sv
module lvl_irq_ctrl_chk #(
    parameter int NUM_SRC = 32
) (
    input logic               clk,
    input logic               rst,
    input logic [7:0]         addr_i,
    input logic               wr_en_i,
    input logic [31:0]        wr_data_i,
    input logic               rd_en_i,
    input logic [31:0]        rd_data_o,
    input logic               irq_o,
    input logic [NUM_SRC-1:0] pend_q,
    input logic [NUM_SRC-1:0] mask_q
);
    logic mask_wr;
    logic rd_mapped;
    assign mask_wr   = wr_en_i && addr_i == 8'h04;
    assign rd_mapped = addr_i == 8'h04 || addr_i == 8'h0C;

    AST_IRQ_FROM_STATE: assert property (@(posedge clk) disable iff (rst)
        irq_o == (|($past(mask_q) & $past(pend_q))));                          // R2
    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (rst)
        mask_wr |=> mask_q == $past(wr_data_i[NUM_SRC-1:0]));                  // R3
    AST_MASK_KEEP: assert property (@(posedge clk) disable iff (rst)
        !mask_wr |=> $stable(mask_q));                                         // R6
    AST_PEND_READ: assert property (@(posedge clk) disable iff (rst)
        rd_en_i && addr_i == 8'h0C |=> rd_data_o[NUM_SRC-1:0] == $past(pend_q)); // R4
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        rd_en_i && !rd_mapped |=> rd_data_o == '0);                            // R6
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !rd_en_i |=> rd_data_o == '0);                                         // R8
endmodule

bind lvl_irq_ctrl lvl_irq_ctrl_chk #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk(clk), .rst(rst), .addr_i(addr_i), .wr_en_i(wr_en_i),
    .wr_data_i(wr_data_i), .rd_en_i(rd_en_i), .rd_data_o(rd_data_o),
    .irq_o(irq_o), .pend_q(pend_q), .mask_q(mask_q)
);

// File: tb/lvl_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module lvl_irq_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] req = '0;
    logic [7:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    lvl_irq_ctrl dut_i (
        .clk(clk), .rst(rst), .req_i(req), .addr_i(addr), .wr_en_i(wr_en),
        .wr_data_i(wr_data), .rd_en_i(rd_en), .rd_data_o(rd_data), .irq_o(irq)
    );

    function automatic logic exp_irq(input logic [31:0] m, input logic [31:0] p);
        return |(m & p);
    endfunction

    function automatic logic [31:0] exp_read(input logic [7:0] a,
                                             input logic [31:0] m,
                                             input logic [31:0] p);
        if (a == 8'h04) return m;
        if (a == 8'h0C) return p;
        return 32'h0;
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        addr = a; rd_en = 1'b1;
        tick();
        rd_en = 1'b0;
        d = rd_data;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [31:0] m;
        void'($urandom(32'd20240611));
        rst = 1'b1;
        req = 32'hFFFF_FFFF;
        repeat (3) tick();
        check("R7 irq in reset", {31'b0, irq}, 32'h0);
        check("R7 rd_data in reset", rd_data, 32'h0);
        req = '0;
        rst = 1'b0;
        tick();
        bus_read(8'h04, d); check("R7 mask after reset", d, 32'h0);
        bus_read(8'h0C, d); check("R7 pend after reset", d, 32'h0);

        bus_write(8'h04, 32'hFFFF_FFFF);
        tick();
        check("R2 no pending no irq", {31'b0, irq}, 32'h0);
        req = 32'h0000_0020;
        tick();
        check("R9 irq one edge late", {31'b0, irq}, 32'h0);
        tick();
        check("R2 irq raised", {31'b0, irq}, 32'h1);
        bus_read(8'h0C, d); check("R1 pend tracks high", d, 32'h20);
        req = '0;
        tick(); tick();
        check("R1 irq drops with level", {31'b0, irq}, 32'h0);
        bus_read(8'h0C, d); check("R1 pend cleared", d, 32'h0);

        req = 32'h0000_0100;
        bus_write(8'h04, 32'h0);
        tick();
        check("R2 masked source", {31'b0, irq}, 32'h0);
        bus_write(8'h04, 32'h0000_0100);
        check("R9 old irq after mask write", {31'b0, irq}, 32'h0);
        tick();
        check("R9 irq after mask edge", {31'b0, irq}, 32'h1);

        bus_write(8'h00, 32'h0);
        bus_write(8'h14, 32'h0);
        bus_read(8'h04, d); check("R5 mask kept", d, 32'h100);
        check("R5 irq kept", {31'b0, irq}, 32'h1);

        bus_write(8'h08, 32'h0);
        bus_write(8'h10, 32'h0);
        bus_write(8'hFC, 32'h0);
        bus_read(8'h04, d); check("R6 mask kept on unmapped write", d, 32'h100);
        bus_read(8'h00, d); check("R6 read 0x00 zero", d, 32'h0);
        bus_read(8'h14, d); check("R6 read 0x14 zero", d, 32'h0);
        bus_read(8'h08, d); check("R6 read 0x08 zero", d, 32'h0);
        tick();
        check("R8 idle read data zero", rd_data, 32'h0);

        for (int k = 0; k < 60; k++) begin
            logic [7:0] ra;
            req = $urandom;
            m   = $urandom;
            if (k % 7 == 0) m = '0;
            bus_write(8'h04, m);
            tick();
            check("R2 random irq", {31'b0, irq}, {31'b0, exp_irq(m, req)});
            bus_read(8'h0C, d); check("R4 random pend", d, req);
            bus_read(8'h04, d); check("R3 random mask", d, m);
            ra = 8'($urandom_range(0, 7) * 4);
            bus_read(ra, d); check("R6 random addr read", d, exp_read(ra, m, req));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule